// File: doc/BRIEF.md
# Load/Store Address and Extension Unit

This unit sits between a core's register file and a byte-addressed 32-bit data memory port and carries out one load or store at a time. It forms the effective address from a base register value and an offset. The offset is either an immediate or a second register value. Three addressing modes are supported. Offset mode leaves the base untouched. Pre-indexed mode uses the sum as the address and writes it back. Post-indexed mode uses the raw base as the address and then writes the sum back.

For loads, the unit takes the returned 32-bit word and picks the byte or halfword lane from the low address bits in little-endian order. It then applies zero or sign extension. For stores, it places the low bits of the source register on every lane and raises only the byte enables that the access touches. A misaligned access raises a flag and is not sent to memory. One request is in flight at a time. Load data and the base write-back appear in the cycle the memory response arrives.

Top module: `ldst_unit`

## Requirements
- R1: With `acc_size` = 2 (word), a load returns all 32 bits of `resp_rdata` unchanged on `ld_data`.
- R2: With `acc_size` = 1 (halfword), a load takes bits [15:0] of the response when address bit 1 is 0, and bits [31:16] when it is 1. It zero-extends the result when `ld_signed` is 0 and sign-extends it when `ld_signed` is 1.
- R3: With `acc_size` = 0 (byte), a load takes byte lane k, which is bits [8k+7:8k], where k is address bits [1:0]. It zero-extends the result when `ld_signed` is 0 and sign-extends it when `ld_signed` is 1.
- R4: A byte store drives the low 8 bits of `st_src` on all four lanes, with `mem_be` = 1 shifted left by address bits [1:0]. A halfword store drives the low 16 bits on both halves, with `mem_be` = 4'b0011 or 4'b1100 chosen by address bit 1. A word store drives `st_src` unchanged with `mem_be` = 4'b1111.
- R5: With `addr_mode` = 0 (offset), `mem_addr` is base + offset and `wb_en` stays low at the response.
- R6: With `addr_mode` = 1 (pre-indexed), `mem_addr` is base + offset, and at the response `wb_en` is high with `wb_value` = base + offset.
- R7: With `addr_mode` = 2 (post-indexed), `mem_addr` is the unmodified base, and at the response `wb_en` is high with `wb_value` = base + offset.
- R8: The offset is `reg_off` when `use_reg_off` is 1 and `imm_off` when it is 0.
- R9: `misalign` rises, and `mem_req` stays low, for a requested halfword access with address bit 0 set or a word access with either of address bits [1:0] set.
- R10: A request is accepted in a cycle where `mem_req` and `mem_ready` are both high. Until `resp_valid` arrives, `mem_req` stays low. `ld_valid` is high only in the response cycle of a load, and never for a store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request from the core |
| is_store | input | 1 | 1 = store, 0 = load |
| acc_size | input | 2 | 0 byte, 1 halfword, 2 word |
| ld_signed | input | 1 | Sign-extend sub-word load |
| addr_mode | input | 2 | 0 offset, 1 pre-indexed, 2 post-indexed |
| use_reg_off | input | 1 | Select register offset |
| base | input | 32 | Base register value |
| imm_off | input | 32 | Immediate offset |
| reg_off | input | 32 | Register offset |
| st_src | input | 32 | Store source register |
| mem_ready | input | 1 | Memory can take a request |
| resp_valid | input | 1 | Memory response valid |
| resp_rdata | input | 32 | Memory read word |
| mem_req | output | 1 | Request to memory |
| mem_we | output | 1 | Write access |
| mem_addr | output | 32 | Byte address |
| mem_be | output | 4 | Byte enables |
| mem_wdata | output | 32 | Write data |
| misalign | output | 1 | Misaligned request flag |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Extended load result |
| wb_en | output | 1 | Base write-back enable |
| wb_value | output | 32 | Updated base value |

## Verification
The bench sweeps every size, signedness, lane and mode against two response words. In these words, each byte lane and each halfword lane holds a value with the top bit set or a value with it clear. Zero and sign extension therefore differ on every lane, and a wrong lane choice changes the result. Immediate offsets are positive and register offsets are negative. This separates the offset source and exposes a swap between the offset sum and the raw base. Stores use a source whose bytes all differ, so a lane placed in the wrong position shows up. A stalled `mem_ready` and a response held back for a cycle test the handshake.

// File: rtl/ldst_unit.sv
module ldst_unit #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          is_store,
  input  logic [1:0]    acc_size,
  input  logic          ld_signed,
  input  logic [1:0]    addr_mode,
  input  logic          use_reg_off,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] imm_off,
  input  logic [AW-1:0] reg_off,
  input  logic [31:0]   st_src,
  input  logic          mem_ready,
  input  logic          resp_valid,
  input  logic [31:0]   resp_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [3:0]    mem_be,
  output logic [31:0]   mem_wdata,
  output logic          misalign,
  output logic          ld_valid,
  output logic [31:0]   ld_data,
  output logic          wb_en,
  output logic [AW-1:0] wb_value
);
  logic [AW-1:0] off, sum, ea;
  logic          bad, busy, accept, done;
  logic          st_q, sg_q, wbf_q;
  logic [1:0]    sz_q, lane_q;
  logic [AW-1:0] wbv_q;
  logic [7:0]    bsel;
  logic [15:0]   hsel;

  assign off = use_reg_off ? reg_off : imm_off;
  assign sum = base + off;
  assign ea  = (addr_mode == 2'd2) ? base : sum;
  assign bad = acc_size[1] ? (ea[1:0] != 2'b00) : (acc_size[0] & ea[0]);

  assign misalign = req & bad;
  assign mem_req  = req & ~busy & ~bad;
  assign accept   = mem_req & mem_ready;
  assign mem_we   = is_store;
  assign mem_addr = ea;

  always_comb begin
    if (acc_size[1]) begin
      mem_be    = 4'b1111;
      mem_wdata = st_src;
    end else if (acc_size[0]) begin
      mem_be    = ea[1] ? 4'b1100 : 4'b0011;
      mem_wdata = {2{st_src[15:0]}};
    end else begin
      mem_be    = 4'b0001 << ea[1:0];
      mem_wdata = {4{st_src[7:0]}};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      st_q   <= 1'b0;
      sg_q   <= 1'b0;
      wbf_q  <= 1'b0;
      sz_q   <= 2'd0;
      lane_q <= 2'd0;
      wbv_q  <= '0;
    end else if (accept) begin
      busy   <= 1'b1;
      st_q   <= is_store;
      sg_q   <= ld_signed;
      wbf_q  <= (addr_mode == 2'd1) || (addr_mode == 2'd2);
      sz_q   <= acc_size;
      lane_q <= ea[1:0];
      wbv_q  <= sum;
    end else if (done) begin
      busy <= 1'b0;
    end
  end

  assign done = busy & resp_valid;

  always_comb begin
    case (lane_q)
      2'd0:    bsel = resp_rdata[7:0];
      2'd1:    bsel = resp_rdata[15:8];
      2'd2:    bsel = resp_rdata[23:16];
      default: bsel = resp_rdata[31:24];
    endcase
    hsel = lane_q[1] ? resp_rdata[31:16] : resp_rdata[15:0];
    if (sz_q[1])      ld_data = resp_rdata;
    else if (sz_q[0]) ld_data = {{16{sg_q & hsel[15]}}, hsel};
    else              ld_data = {{24{sg_q & bsel[7]}}, bsel};
  end

  assign ld_valid = done & ~st_q;
  assign wb_en    = done & wbf_q;
  assign wb_value = wbv_q;
endmodule

module ldst_unit_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_ready,
  input logic          mem_we,
  input logic [1:0]    acc_size,
  input logic [1:0]    addr_mode,
  input logic          use_reg_off,
  input logic [AW-1:0] base,
  input logic [AW-1:0] imm_off,
  input logic [AW-1:0] reg_off,
  input logic [AW-1:0] mem_addr,
  input logic [3:0]    mem_be,
  input logic          misalign,
  input logic          resp_valid,
  input logic          ld_valid,
  input logic          wb_en,
  input logic [AW-1:0] wb_value
);
  logic          pend;
  logic [AW-1:0] exp_wb;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend   <= 1'b0;
      exp_wb <= '0;
    end else if (mem_req && mem_ready) begin
      pend   <= 1'b1;
      exp_wb <= base + (use_reg_off ? reg_off : imm_off);
    end else if (resp_valid) begin
      pend <= 1'b0;
    end
  end

  // R10
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> !mem_req);
  // R10
  ld_in_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> (resp_valid && pend));
  // R7
  post_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && addr_mode == 2'd2) |-> (mem_addr == base));
  // R9
  misalign_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> !mem_req);
  // R4
  byte_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && acc_size == 2'd0) |-> ($countones(mem_be) == 1));
  // R6
  wb_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (pend && wb_value == exp_wb));
endmodule

bind ldst_unit ldst_unit_chk #(.AW(AW)) chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_ready(mem_ready),
  .mem_we(mem_we), .acc_size(acc_size), .addr_mode(addr_mode),
  .use_reg_off(use_reg_off), .base(base), .imm_off(imm_off),
  .reg_off(reg_off), .mem_addr(mem_addr), .mem_be(mem_be),
  .misalign(misalign), .resp_valid(resp_valid), .ld_valid(ld_valid),
  .wb_en(wb_en), .wb_value(wb_value)
);

// File: tb/tb_ldst_unit.sv
module tb_ldst_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req, is_store, ld_signed, use_reg_off, mem_ready, resp_valid;
  logic [1:0]  acc_size, addr_mode;
  logic [31:0] base, imm_off, reg_off, st_src, resp_rdata;
  logic        mem_req, mem_we, misalign, ld_valid, wb_en;
  logic [31:0] mem_addr, mem_wdata, ld_data, wb_value;
  logic [3:0]  mem_be;
  int          n_chk = 0, n_fail = 0;
  bit          ended = 0;

  always #4 clk = ~clk;

  ldst_unit dut (
    .clk(clk), .rst_n(rst_n), .req(req), .is_store(is_store),
    .acc_size(acc_size), .ld_signed(ld_signed), .addr_mode(addr_mode),
    .use_reg_off(use_reg_off), .base(base), .imm_off(imm_off),
    .reg_off(reg_off), .st_src(st_src), .mem_ready(mem_ready),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .misalign(misalign), .ld_valid(ld_valid),
    .ld_data(ld_data), .wb_en(wb_en), .wb_value(wb_value)
  );

  task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_load(input int sz, input bit sg, input int lane,
                                           input logic [31:0] rd);
    longint v;
    if (sz == 2) return rd;
    if (sz == 1) begin
      v = (rd / (64'd1 << (16 * (lane / 2)))) % 65536;
      if (sg && v >= 32768) v = v + 64'hFFFF0000;
    end else begin
      v = (rd / (64'd1 << (8 * lane))) % 256;
      if (sg && v >= 128) v = v + 64'hFFFFFF00;
    end
    return v[31:0];
  endfunction

  task automatic access(input bit st, input int sz, input bit sg, input int md,
                        input bit ur, input logic [31:0] b, input logic [31:0] rd);
    logic [31:0] off, sm, ea, exp_w;
    logic [3:0]  exp_be;
    bit          bad;
    int          lane;
    string       rtag;
    @(negedge clk);
    req = 1; is_store = st; acc_size = 2'(sz); ld_signed = sg; addr_mode = 2'(md);
    use_reg_off = ur; base = b; mem_ready = 1; resp_valid = 0;
    #1;
    off  = ur ? reg_off : imm_off;
    sm   = b + off;
    ea   = (md == 2) ? b : sm;
    lane = int'(ea % 4);
    bad  = (sz == 2 && lane != 0) || (sz == 1 && (lane % 2) == 1);
    if (bad) begin
      check("R9 misalign", {31'd0, misalign}, 32'd1);
      check("R9 mem_req", {31'd0, mem_req}, 32'd0);
      @(negedge clk); req = 0;
      return;
    end
    rtag = (md == 0) ? "R5 addr" : (md == 1) ? "R6 addr" : "R7 addr";
    check("R10 mem_req", {31'd0, mem_req}, 32'd1);
    check(ur ? "R8 reg offset addr" : rtag, mem_addr, ea);
    if (st) begin
      if (sz == 2) begin exp_be = 4'hF; exp_w = st_src; end
      else if (sz == 1) begin
        exp_be = (lane >= 2) ? 4'b1100 : 4'b0011;
        exp_w  = {16'd0, st_src[15:0]} * 32'h00010001;
      end else begin
        exp_be = 4'(1 << lane);
        exp_w  = {24'd0, st_src[7:0]} * 32'h01010101;
      end
      check("R4 be", {28'd0, mem_be}, {28'd0, exp_be});
      check("R4 wdata", mem_wdata, exp_w);
    end
    @(negedge clk);
    req = 0; resp_valid = 1; resp_rdata = rd;
    #1;
    check("R10 ld_valid", {31'd0, ld_valid}, {31'd0, !st});
    if (!st)
      check(sz == 2 ? "R1 word" : sz == 1 ? "R2 half" : "R3 byte",
            ld_data, exp_load(sz, sg, lane, rd));
    check(md == 0 ? "R5 wb_en" : "R6 R7 wb_en", {31'd0, wb_en}, {31'd0, md != 0});
    if (md != 0) check(md == 1 ? "R6 wb_value" : "R7 wb_value", wb_value, sm);
    @(negedge clk);
    resp_valid = 0;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] pats [2];
    pats[0] = 32'h80FF7F01;
    pats[1] = 32'h7F80FF00;
    rst_n = 0; req = 0; is_store = 0; acc_size = 0; ld_signed = 0; addr_mode = 0;
    use_reg_off = 0; base = 0; imm_off = 32'h10; reg_off = 32'hFFFFFFF8;
    st_src = 32'hA1B2C3D4; mem_ready = 0; resp_valid = 0; resp_rdata = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1; #1;
    check("R10 reset mem_req", {31'd0, mem_req}, 32'd0);
    check("R10 reset ld_valid", {31'd0, ld_valid}, 32'd0);
    check("R6 reset wb_en", {31'd0, wb_en}, 32'd0);

    for (int p = 0; p < 2; p++)
      for (int sz = 0; sz < 3; sz++)
        for (int sg = 0; sg < 2; sg++)
          for (int md = 0; md < 3; md++)
            for (int ur = 0; ur < 2; ur++)
              for (int ln = 0; ln < 4; ln++)
                access(1'b0, sz, sg[0], md, ur[0], 32'h1000 + 32'(ln), pats[p]);

    for (int sz = 0; sz < 3; sz++)
      for (int md = 0; md < 3; md++)
        for (int ln = 0; ln < 4; ln++)
          access(1'b1, sz, 1'b0, md, 1'b1, 32'h2000 + 32'(ln), 32'h0);

    // R10 stall on mem_ready, then a delayed response
    @(negedge clk);
    req = 1; is_store = 0; acc_size = 2; addr_mode = 0; use_reg_off = 0;
    base = 32'h3000; mem_ready = 0; #1;
    check("R10 stalled mem_req", {31'd0, mem_req}, 32'd1);
    @(negedge clk); #1;
    check("R10 still waiting", {31'd0, mem_req}, 32'd1);
    mem_ready = 1;
    @(negedge clk); #1;
    check("R10 hold while pending", {31'd0, mem_req}, 32'd0);
    check("R10 no early ld_valid", {31'd0, ld_valid}, 32'd0);
    req = 0; resp_valid = 1; resp_rdata = 32'hCAFE1234; #1;
    check("R10 ld_valid", {31'd0, ld_valid}, 32'd1);
    check("R1 word after stall", ld_data, 32'hCAFE1234);
    @(negedge clk); resp_valid = 0; #1;
    check("R10 ld_valid drops", {31'd0, ld_valid}, 32'd0);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule